// File: doc/BRIEF.md
# Register-or-Constant ALU Execution Stage

This block is the execute step of a small 16-bit processor with an eight-entry register file. Each cycle that `in_valid` is high it takes an operation code, the destination register's value, the source register's value, the 3-bit source field, a constant-select bit, a byte-mode bit and the current condition flags. One clock later it presents the result, the write enables for the destination and source registers, and the new carry, zero, negative and overflow flags.

It covers additive arithmetic (add, add with carry, subtract, subtract with carry, compare), bitwise logic (XOR, AND, OR, bit test, bit clear, bit set), register moves (move, swap) and single-operand operations (arithmetic shift right, rotate right through carry, byte swap, sign extension). For the arithmetic and logic group, the constant-select bit replaces the source register's value with an entry from a fixed constant table. Compare is the exception and always reads the register. The register file itself lives outside the block and is only ever written through the reported enables.

Top module: `rc_alu_exec`

## Requirements
- R1: With `in_rc`=1 and an opcode from ADD (0) through BIS (10) other than CMP (4), the source operand is taken from `in_src_idx`: 0→0x0000, 1→0x0001, 2→0x0002, 3→0x0004, 4→0x0008, 5→0x0010, 6→0x0020, 7→0xFFFF.
- R2: CMP (4) and every opcode above BIS ignore `in_rc` and use `in_src_val`.
- R3: Opcodes ADD=0, ADDC=1, SUB=2, SUBC=3 write DST+SRC, DST+SRC+C, DST+~SRC+1 and DST+~SRC+C. C is the carry out of the operand's top bit.
- R4: CMP (4) and BIT (8) update the flags from DST+~SRC+1 and DST&SRC respectively, and drive `out_wr_dst`=0.
- R5: XOR=5, AND=6, OR=7, BIC=9 and BIS=10 write DST^SRC, DST&SRC, DST|SRC, DST&~SRC and DST|(1<<SRC). For BIS, a shift amount at or beyond the operand width sets no bit.
- R6: SWPB (15) writes DST with its bytes exchanged. SXT (16) writes bit 7 of DST into bits 15..8. Both always work on the full word.
- R7: SRA (13) shifts DST right by one and keeps its sign bit. RRC (14) shifts the incoming carry into the top bit. Both put the old bit 0 into C.
- R8: SWAP (12) writes the source value to the destination and the destination value to the source (`out_src_res`). Both enables are high and the flags are unchanged.
- R9: With `in_byte`=1, every opcode except SWAP, SWPB and SXT works on bits 7..0 only. C, N and V are then taken at bit 7, Z is taken from the low byte, and the result's high byte equals DST's high byte.
- R10: V is set when the two adder operands have the same sign and the sum's sign differs. For subtract forms, the complemented source is the operand.
- R11: Logic opcodes keep C and V. MOV (11) and SWAP keep all flags. Opcodes 17..31 write nothing and keep all flags.
- R12: After a synchronous active-low reset, `out_valid`, both write enables and all four flags are 0. Results appear exactly one cycle after `in_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 5 | Opcode |
| in_dst | input | 16 | Destination register value |
| in_src_val | input | 16 | Source register value |
| in_src_idx | input | 3 | Source field (register number or constant index) |
| in_rc | input | 1 | 1 selects the constant table |
| in_byte | input | 1 | 1 selects byte mode |
| in_c | input | 1 | Incoming carry |
| in_z | input | 1 | Incoming zero flag |
| in_n | input | 1 | Incoming negative flag |
| in_v | input | 1 | Incoming overflow flag |
| out_valid | output | 1 | Result valid |
| out_res | output | 16 | Value for the destination register |
| out_wr_dst | output | 1 | Write destination register |
| out_src_res | output | 16 | Value for the source register (swap) |
| out_wr_src | output | 1 | Write source register |
| out_c | output | 1 | Carry flag |
| out_z | output | 1 | Zero flag |
| out_n | output | 1 | Negative flag |
| out_v | output | 1 | Overflow flag |

## Verification
The bench targets index 7 of the constant table, which adds as minus one and must raise carry. A design that took only a shifted one there would get both sum and carry wrong. Compare with the constant bit set must read the register: a substituting design reports a non-zero result for equal operands. Subtract-with-carry is run with both carry values, so a fixed +1 shows up as an off-by-one. Bit set is tried with shift amounts of 15, 20 and 8 in byte mode, where a wrapped shift count would set a stray bit. Byte-mode add, shift and move check that the high byte is kept and that carry and overflow are taken at bit 7. Rotate with carry in and the swap pair catch a design that drops the carry or writes only one register.

// File: rtl/rc_alu_pkg.sv
// Package: opcode encoding shared by the execution stage and its units.
// Assumes a 5-bit opcode field; codes 17..31 are treated as no-operation.
package rc_alu_pkg;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADDC = 5'd1,
        OP_SUB  = 5'd2,
        OP_SUBC = 5'd3,
        OP_CMP  = 5'd4,
        OP_XOR  = 5'd5,
        OP_AND  = 5'd6,
        OP_OR   = 5'd7,
        OP_BIT  = 5'd8,
        OP_BIC  = 5'd9,
        OP_BIS  = 5'd10,
        OP_MOV  = 5'd11,
        OP_SWAP = 5'd12,
        OP_SRA  = 5'd13,
        OP_RRC  = 5'd14,
        OP_SWPB = 5'd15,
        OP_SXT  = 5'd16
    } alu_op_e;

    typedef struct packed {
        logic c;
        logic z;
        logic n;
        logic v;
    } flags_t;

endpackage

// File: rtl/rc_operand_sel.sv
// Operand select: picks the source register value or a constant-table entry.
// Assumes a 3-bit index; entries 1..6 are powers of two, 0 is zero, 7 is all ones.
module rc_operand_sel
    import rc_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e      op,
    input  logic [W-1:0] src_val,
    input  logic [2:0]   src_idx,
    input  logic         rc,
    output logic [W-1:0] operand
);

    logic         use_const;
    logic [W-1:0] const_val;

    // Constant table entry for the source index.
    always_comb begin
        case (src_idx)
            3'd0:    const_val = '0;
            3'd7:    const_val = '1;
            default: const_val = {{(W-1){1'b0}}, 1'b1} << (src_idx - 3'd1);
        endcase
    end

    // Substitute the constant only for the arithmetic/logic group minus compare.
    always_comb begin
        use_const = rc && (op <= OP_BIS) && (op != OP_CMP);
        operand   = use_const ? const_val : src_val;
    end

    // R1: a substituted operand is zero, a single power of two, or all ones.
    always_comb begin
        if (use_const) begin
            p_const_shape_r1: assert ($countones(operand) <= 1 || (&operand));
        end
    end

endmodule

// File: rtl/rc_addsub.sv
// Adder for add/add-carry/subtract/subtract-carry/compare.
// Assumes W is even; in byte mode only the low W/2 bits are summed and the
// upper half of the destination is passed through. Flags taken at the
// active width's top bit.
module rc_addsub
    import rc_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         byte_mode,
    input  logic         c_in,
    output logic [W-1:0] sum,
    output logic         c_out,
    output logic         v_out
);

    localparam int HB = W / 2;

    logic         is_sub;
    logic         cin;
    logic [W-1:0] bb;
    logic [W:0]   wide;
    logic [HB:0]  narrow;

    // Choose operand polarity and carry-in for the requested arithmetic form.
    always_comb begin
        is_sub = (op == OP_SUB) || (op == OP_SUBC) || (op == OP_CMP);
        bb     = is_sub ? ~b : b;
        case (op)
            OP_ADDC, OP_SUBC: cin = c_in;
            OP_SUB,  OP_CMP:  cin = 1'b1;
            default:          cin = 1'b0;
        endcase
    end

    // Full-width and half-width sums, then selection with carry and overflow.
    always_comb begin
        wide   = {1'b0, a} + {1'b0, bb} + {{W{1'b0}}, cin};
        narrow = {1'b0, a[HB-1:0]} + {1'b0, bb[HB-1:0]} + {{HB{1'b0}}, cin};
        if (byte_mode) begin
            sum   = {a[W-1:HB], narrow[HB-1:0]};
            c_out = narrow[HB];
            v_out = (a[HB-1] == bb[HB-1]) && (narrow[HB-1] != a[HB-1]);
        end else begin
            sum   = wide[W-1:0];
            c_out = wide[W];
            v_out = (a[W-1] == bb[W-1]) && (wide[W-1] != a[W-1]);
        end
    end

endmodule

// File: rtl/rc_logic_shift.sv
// Bitwise logic, move, shift/rotate, byte swap and sign extension.
// Assumes W is even. Byte mode is already cleared by the caller for the
// word-only operations. c_out is the bit shifted out of bit 0.
module rc_logic_shift
    import rc_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         byte_mode,
    input  logic         c_in,
    output logic [W-1:0] res,
    output logic         c_out
);

    localparam int HB  = W / 2;
    localparam int SHW = $clog2(W);

    logic [W-1:0] bit_mask;
    logic [W-1:0] raw;
    logic         in_range;
    logic         merge_low;

    // One-hot mask for bit set; no bit when the index exceeds the active width.
    always_comb begin
        in_range = byte_mode ? (b < W'(HB)) : (b < W'(W));
        bit_mask = in_range ? ({{(W-1){1'b0}}, 1'b1} << b[SHW-1:0]) : '0;
    end

    // Raw result for every operation of this unit.
    always_comb begin
        case (op)
            OP_XOR:          raw = a ^ b;
            OP_AND, OP_BIT:  raw = a & b;
            OP_OR:           raw = a | b;
            OP_BIC:          raw = a & ~b;
            OP_BIS:          raw = a | bit_mask;
            OP_MOV:          raw = b;
            OP_SRA:          raw = byte_mode ? {a[W-1:HB], a[HB-1], a[HB-1:1]}
                                             : {a[W-1], a[W-1:1]};
            OP_RRC:          raw = byte_mode ? {a[W-1:HB], c_in, a[HB-1:1]}
                                             : {c_in, a[W-1:1]};
            OP_SWPB:         raw = {a[HB-1:0], a[W-1:HB]};
            OP_SXT:          raw = {{HB{a[HB-1]}}, a[HB-1:0]};
            default:         raw = a;
        endcase
    end

    // Byte mode for two-operand ops keeps the destination's high half.
    always_comb begin
        merge_low = byte_mode && (op >= OP_XOR) && (op <= OP_MOV);
        res       = merge_low ? {a[W-1:HB], raw[HB-1:0]} : raw;
        c_out     = a[0];
    end

endmodule

// File: rtl/rc_alu_exec.sv
// Execution stage top: selects the operand, runs the adder or the logic/shift
// unit, forms write enables and flags, and registers everything for one cycle.
// Assumes the register file is outside; it is written only via out_wr_*.
// Synchronous active-low reset clears valid, enables and flags.
module rc_alu_exec
    import rc_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [4:0]   in_op,
    input  logic [W-1:0] in_dst,
    input  logic [W-1:0] in_src_val,
    input  logic [2:0]   in_src_idx,
    input  logic         in_rc,
    input  logic         in_byte,
    input  logic         in_c,
    input  logic         in_z,
    input  logic         in_n,
    input  logic         in_v,
    output logic         out_valid,
    output logic [W-1:0] out_res,
    output logic         out_wr_dst,
    output logic [W-1:0] out_src_res,
    output logic         out_wr_src,
    output logic         out_c,
    output logic         out_z,
    output logic         out_n,
    output logic         out_v
);

    localparam int HB = W / 2;

    alu_op_e      op;
    logic         eff_byte;
    logic [W-1:0] operand;
    logic [W-1:0] add_res;
    logic         add_c;
    logic         add_v;
    logic [W-1:0] ls_res;
    logic         ls_c;
    logic [W-1:0] nxt_res;
    logic [W-1:0] nxt_src_res;
    logic         nxt_wr_dst;
    logic         nxt_wr_src;
    flags_t       nxt_f;
    logic         res_z;
    logic         res_n;

    // Decode opcode and force word mode for the word-only operations.
    always_comb begin
        op       = alu_op_e'(in_op);
        eff_byte = in_byte && (op != OP_SWAP) && (op != OP_SWPB) && (op != OP_SXT);
    end

    rc_operand_sel #(.W(W)) u_sel (
        .op      (op),
        .src_val (in_src_val),
        .src_idx (in_src_idx),
        .rc      (in_rc),
        .operand (operand)
    );

    rc_addsub #(.W(W)) u_add (
        .op        (op),
        .a         (in_dst),
        .b         (operand),
        .byte_mode (eff_byte),
        .c_in      (in_c),
        .sum       (add_res),
        .c_out     (add_c),
        .v_out     (add_v)
    );

    rc_logic_shift #(.W(W)) u_ls (
        .op        (op),
        .a         (in_dst),
        .b         (operand),
        .byte_mode (eff_byte),
        .c_in      (in_c),
        .res       (ls_res),
        .c_out     (ls_c)
    );

    // Pick result and write enables by operation class.
    always_comb begin
        nxt_src_res = in_dst;
        nxt_wr_src  = 1'b0;
        nxt_wr_dst  = 1'b0;
        nxt_res     = in_dst;
        if (op <= OP_CMP) begin
            nxt_res    = add_res;
            nxt_wr_dst = (op != OP_CMP);
        end else if (op <= OP_MOV) begin
            nxt_res    = ls_res;
            nxt_wr_dst = (op != OP_BIT);
        end else if (op == OP_SWAP) begin
            nxt_res    = in_src_val;
            nxt_wr_dst = 1'b1;
            nxt_wr_src = 1'b1;
        end else if (op <= OP_SXT) begin
            nxt_res    = ls_res;
            nxt_wr_dst = 1'b1;
        end
    end

    // Zero and negative at the active width.
    always_comb begin
        res_z = eff_byte ? (nxt_res[HB-1:0] == '0) : (nxt_res == '0);
        res_n = eff_byte ? nxt_res[HB-1] : nxt_res[W-1];
    end

    // Next flags: each class updates only the flags it owns.
    always_comb begin
        nxt_f = '{c: in_c, z: in_z, n: in_n, v: in_v};
        if (op <= OP_CMP) begin
            nxt_f = '{c: add_c, z: res_z, n: res_n, v: add_v};
        end else if (op <= OP_BIS) begin
            nxt_f.z = res_z;
            nxt_f.n = res_n;
        end else if (op == OP_SRA || op == OP_RRC) begin
            nxt_f.c = ls_c;
            nxt_f.z = res_z;
            nxt_f.n = res_n;
        end else if (op == OP_SWPB || op == OP_SXT) begin
            nxt_f.z = res_z;
            nxt_f.n = res_n;
        end
    end

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_wr_dst  <= 1'b0;
            out_wr_src  <= 1'b0;
            out_res     <= '0;
            out_src_res <= '0;
            out_c       <= 1'b0;
            out_z       <= 1'b0;
            out_n       <= 1'b0;
            out_v       <= 1'b0;
        end else begin
            out_valid  <= in_valid;
            out_wr_dst <= in_valid && nxt_wr_dst;
            out_wr_src <= in_valid && nxt_wr_src;
            if (in_valid) begin
                out_res     <= nxt_res;
                out_src_res <= nxt_src_res;
                out_c       <= nxt_f.c;
                out_z       <= nxt_f.z;
                out_n       <= nxt_f.n;
                out_v       <= nxt_f.v;
            end
        end
    end

    // R4: compare and bit test never request a destination write.
    p_flag_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_op == 5'd4 || in_op == 5'd8) |=> out_valid && !out_wr_dst);

    // R7: shift and rotate move the old bit 0 into carry.
    p_shift_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_op == 5'd13 || in_op == 5'd14) |=> out_c == $past(in_dst[0]));

    // R8: swap writes both registers, the source receiving the old destination.
    p_swap_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_op == 5'd12 |=> out_wr_dst && out_wr_src && out_src_res == $past(in_dst));

    // R9: byte mode preserves the destination's high half.
    p_byte_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && eff_byte |=> out_res[W-1:HB] == $past(in_dst[W-1:HB]));

    // R11: logic group leaves carry and overflow as they came in.
    p_logic_cv_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_op >= 5'd5 && in_op <= 5'd10 |=> out_c == $past(in_c) && out_v == $past(in_v));

    // R12: no write request without a valid result.
    p_quiet_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !out_wr_dst && !out_wr_src);

endmodule

// File: tb/rc_alu_exec_tb.sv
// Scoreboard bench: the driver pushes expected items, the monitor pops and compares.
module rc_alu_exec_tb;

    typedef struct packed {
        logic [15:0] res;
        logic [15:0] src_res;
        logic        wr_dst;
        logic        wr_src;
        logic        c;
        logic        z;
        logic        n;
        logic        v;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  in_op = '0;
    logic [15:0] in_dst = '0;
    logic [15:0] in_src_val = '0;
    logic [2:0]  in_src_idx = '0;
    logic        in_rc = 1'b0;
    logic        in_byte = 1'b0;
    logic        in_c = 1'b0;
    logic        in_z = 1'b0;
    logic        in_n = 1'b0;
    logic        in_v = 1'b0;
    logic        out_valid;
    logic [15:0] out_res;
    logic        out_wr_dst;
    logic [15:0] out_src_res;
    logic        out_wr_src;
    logic        out_c;
    logic        out_z;
    logic        out_n;
    logic        out_v;

    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;
    exp_t  exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    rc_alu_exec u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_dst(in_dst), .in_src_val(in_src_val), .in_src_idx(in_src_idx),
        .in_rc(in_rc), .in_byte(in_byte), .in_c(in_c), .in_z(in_z),
        .in_n(in_n), .in_v(in_v), .out_valid(out_valid), .out_res(out_res),
        .out_wr_dst(out_wr_dst), .out_src_res(out_src_res),
        .out_wr_src(out_wr_src), .out_c(out_c), .out_z(out_z),
        .out_n(out_n), .out_v(out_v)
    );

    // Reference model written from the requirements.
    function automatic exp_t model(logic [4:0] op, logic [15:0] d, logic [15:0] s,
                                   logic [2:0] idx, logic rc, logic by, logic [3:0] f);
        exp_t e;
        logic [31:0] b, a, bb, sum, r, mask, cin;
        int msb;
        logic eb, zn;
        e = '{res: d, src_res: d, wr_dst: 1'b0, wr_src: 1'b0,
              c: f[3], z: f[2], n: f[1], v: f[0]};
        if (rc && op <= 5'd10 && op != 5'd4)
            b = (idx == 3'd0) ? 32'h0 : (idx == 3'd7) ? 32'hFFFF : (32'h1 << (idx - 3'd1));
        else
            b = {16'h0, s};
        eb   = by && op != 5'd12 && op != 5'd15 && op != 5'd16;
        mask = eb ? 32'hFF : 32'hFFFF;
        msb  = eb ? 7 : 15;
        a    = {16'h0, d} & mask;
        r    = a;
        zn   = 1'b0;
        if (op <= 5'd4) begin
            bb   = ((op >= 5'd2) ? ~b : b) & mask;
            cin  = (op == 5'd0) ? 0 : (op == 5'd2 || op == 5'd4) ? 1 : {31'h0, f[3]};
            sum  = a + bb + cin;
            r    = sum & mask;
            e.c  = sum[msb+1];
            e.v  = (a[msb] == bb[msb]) && (r[msb] != a[msb]);
            e.wr_dst = (op != 5'd4);
            zn   = 1'b1;
        end else if (op <= 5'd11) begin
            case (op)
                5'd5:       r = a ^ b;
                5'd6, 5'd8: r = a & b;
                5'd7:       r = a | b;
                5'd9:       r = a & ~b;
                5'd10:      r = a | ((b <= 32'(msb)) ? (32'h1 << b) : 32'h0);
                default:    r = b;
            endcase
            r = r & mask;
            e.wr_dst = (op != 5'd8);
            zn = (op != 5'd11);
        end else if (op == 5'd12) begin
            e.wr_dst = 1'b1;
            e.wr_src = 1'b1;
            e.res = s;
            return e;
        end else if (op <= 5'd16) begin
            case (op)
                5'd13:   r = (a >> 1) | ({31'h0, a[msb]} << msb);
                5'd14:   r = (a >> 1) | ({31'h0, f[3]} << msb);
                5'd15:   r = {16'h0, d[7:0], d[15:8]};
                default: r = {16'h0, {8{d[7]}}, d[7:0]};
            endcase
            if (op == 5'd13 || op == 5'd14) e.c = a[0];
            e.wr_dst = 1'b1;
            zn = 1'b1;
        end
        if (zn) begin
            e.z = (r == 0);
            e.n = r[msb];
        end
        if (e.wr_dst) e.res = ({16'h0, d} & ~mask & 32'hFFFF | r) & 32'hFFFF;
        return e;
    endfunction

    // Driver: apply one operation and push its expected outcome. f = {c,z,n,v}.
    task automatic drive(input logic [4:0] op, input logic [15:0] d, input logic [15:0] s,
                         input logic [2:0] idx, input logic rc, input logic by,
                         input logic [3:0] f, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_dst = d; in_src_val = s; in_src_idx = idx;
        in_rc = rc; in_byte = by; {in_c, in_z, in_n, in_v} = f;
        exp_q.push_back(model(op, d, s, idx, rc, by, f));
        tag_q.push_back(tag);
    endtask

    // Monitor: compare each registered result against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            exp_t e, act;
            string t;
            bit ok;
            act = '{res: out_res, src_res: out_src_res, wr_dst: out_wr_dst,
                    wr_src: out_wr_src, c: out_c, z: out_z, n: out_n, v: out_v};
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R12 unexpected result actual=%h expected=none", act);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                ok = act.wr_dst == e.wr_dst && act.wr_src == e.wr_src &&
                     act.c == e.c && act.z == e.z && act.n == e.n && act.v == e.v &&
                     (!e.wr_dst || act.res == e.res) && (!e.wr_src || act.src_res == e.src_res);
                if (!ok) begin
                    fails++;
                    $display("FAIL %s actual=%h expected=%h", t, act, e);
                end
            end
        end
    end

    // Watchdog: a hang is a failed check and still reaches the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state seen at the ports.
        checks++;
        if (out_valid || out_wr_dst || out_wr_src || out_c || out_z || out_n || out_v) begin
            fails++;
            $display("FAIL R12 reset actual=%b expected=0000000",
                     {out_valid, out_wr_dst, out_wr_src, out_c, out_z, out_n, out_v});
        end
        // R1: every constant-table entry through ADD.
        for (int i = 0; i < 8; i++) drive(5'd0, 16'h1000, 16'h5555, 3'(i), 1'b1, 1'b0, 4'b0000, "R1");
        // R2: compare and move ignore the constant bit.
        drive(5'd4, 16'h1234, 16'h1234, 3'd3, 1'b1, 1'b0, 4'b0000, "R2");
        drive(5'd11, 16'h0000, 16'hABCD, 3'd2, 1'b1, 1'b0, 4'b0000, "R2");
        // R3: arithmetic forms, carry in both ways.
        drive(5'd2, 16'h0005, 16'h0007, 3'd1, 1'b0, 1'b0, 4'b0000, "R3");
        drive(5'd3, 16'h0005, 16'h0003, 3'd1, 1'b0, 1'b0, 4'b0000, "R3");
        drive(5'd3, 16'h0005, 16'h0003, 3'd1, 1'b0, 1'b0, 4'b1000, "R3");
        drive(5'd1, 16'hFFFF, 16'h0001, 3'd1, 1'b0, 1'b0, 4'b1000, "R3");
        // R4: flag-only operations.
        drive(5'd4, 16'h0003, 16'h0003, 3'd1, 1'b0, 1'b0, 4'b0000, "R4");
        drive(5'd8, 16'h00F0, 16'h000F, 3'd1, 1'b0, 1'b0, 4'b0000, "R4");
        // R5: logic, bit clear, bit set including out-of-range index.
        drive(5'd9, 16'hFFFF, 16'h00F0, 3'd1, 1'b0, 1'b0, 4'b0000, "R5");
        drive(5'd10, 16'h0000, 16'h0000, 3'd3, 1'b1, 1'b0, 4'b0000, "R5");
        drive(5'd10, 16'h0001, 16'd15, 3'd1, 1'b0, 1'b0, 4'b0000, "R5");
        drive(5'd10, 16'h0001, 16'd20, 3'd1, 1'b0, 1'b0, 4'b0000, "R5");
        drive(5'd5, 16'hA5A5, 16'hFFFF, 3'd1, 1'b0, 1'b0, 4'b0000, "R5");
        drive(5'd7, 16'h0F00, 16'h00F0, 3'd1, 1'b0, 1'b0, 4'b0000, "R5");
        // R6: byte swap and sign extension.
        drive(5'd15, 16'h12AB, 16'h0000, 3'd1, 1'b0, 1'b1, 4'b0000, "R6");
        drive(5'd16, 16'h0080, 16'h0000, 3'd1, 1'b0, 1'b0, 4'b0000, "R6");
        drive(5'd16, 16'h127F, 16'h0000, 3'd1, 1'b0, 1'b0, 4'b0000, "R6");
        // R7: shift and rotate.
        drive(5'd13, 16'h8003, 16'h0000, 3'd1, 1'b0, 1'b0, 4'b0000, "R7");
        drive(5'd14, 16'h0002, 16'h0000, 3'd1, 1'b0, 1'b0, 4'b1000, "R7");
        // R8: swap.
        drive(5'd12, 16'h1111, 16'h2222, 3'd1, 1'b0, 1'b0, 4'b1011, "R8");
        // R9: byte mode.
        drive(5'd0, 16'h12FF, 16'h0001, 3'd1, 1'b0, 1'b1, 4'b0000, "R9");
        drive(5'd11, 16'hAA00, 16'h3355, 3'd1, 1'b0, 1'b1, 4'b0000, "R9");
        drive(5'd13, 16'h7781, 16'h0000, 3'd1, 1'b0, 1'b1, 4'b0000, "R9");
        drive(5'd10, 16'h4400, 16'd8, 3'd1, 1'b0, 1'b1, 4'b0000, "R9");
        // R10: overflow.
        drive(5'd0, 16'h7FFF, 16'h0001, 3'd1, 1'b0, 1'b0, 4'b0000, "R10");
        drive(5'd2, 16'h8000, 16'h0001, 3'd1, 1'b0, 1'b0, 4'b0000, "R10");
        drive(5'd0, 16'h007F, 16'h0001, 3'd1, 1'b0, 1'b1, 4'b0000, "R10");
        // R11: logic keeps C/V; unknown opcode does nothing.
        drive(5'd6, 16'h00FF, 16'h0F0F, 3'd1, 1'b0, 1'b0, 4'b1001, "R11");
        drive(5'd20, 16'h1234, 16'h5678, 3'd1, 1'b0, 1'b0, 4'b1010, "R11");
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        // R12: every pushed item was produced exactly one cycle later.
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R12 pending actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule